// File: doc/BRIEF.md
# MII Management Frame PHY Slave

This block sits on the PHY side of a bit-serial MII management link. The host controls three signals: the management clock, a data bit it drives towards the PHY, and a direction bit. The direction bit is set when the host has released the data line and expects the PHY to drive it. The block samples these signals with its own system clock and acts only on rising edges of the management clock. It recognises a start delimiter, a two-bit opcode, a PHY address and a register address. It then either shifts a 16-bit register out on its data output or collects 16 bits and stores them.

The storage is a register array of 32 PHYs by 32 registers of 16 bits. A register is selected by the PHY address times 32 plus the register address. One bit counter runs through the whole frame. After the data phase the block stays idle until that counter reaches 31, and only then does it look for a new start delimiter. A one-cycle error pulse flags a host that claims to be reading during a phase in which it must be driving.

Top module: `mdio_phy_slave`

## Requirements
- R1: After reset `mdi_o` and `dir_err_o` are 0. Every register reads 0, except PHY 0 register 1, which reads 16'h502C. That value sets bits 14, 12, 5, 3 and 2, meaning 100BASE-TX full duplex, 10BASE-T full duplex, auto-negotiation complete, auto-negotiation capable and link up.
- R2: Only a system-clock sample in which `mdc_i` is 1 after a sample in which it was 0 counts as a management edge. While `mdc_i` stays high, `mdi_o` holds its value and decoding does not advance, whatever `mdo_i` does.
- R3: A frame starts with `mdo_i`=0 on one edge and then `mdo_i`=1 on a later edge, both with `host_rd_i`=0. If `host_rd_i`=1 on an edge while the block waits for the 1, the block returns to waiting for the 0.
- R4: The next two edges carry the opcode, first bit in the high position. Binary 10 is a read and binary 01 is a write. With 00 or 11 the block returns to its reset state at the turnaround position and drives no data.
- R5: The next ten edges carry a 5-bit PHY address and then a 5-bit register address, each MSB first. They select register index PHY*32+reg.
- R6: In a read, `mdi_o` is 0 for the single turnaround edge. On the following 16 edges `mdi_o` carries the selected register MSB first, but only on edges where `host_rd_i`=1; otherwise it is 0. Each bit appears one system clock after the edge.
- R7: In a write, two turnaround edges are skipped. The next 16 edges are collected MSB first, and the word is stored on the 16th edge, so a later read returns it.
- R8: After a read the block ignores two further edges, and after a write it ignores one, before it accepts a new start delimiter.
- R9: `mdi_o` is 0 after every edge that is not a read-data edge.
- R10: `dir_err_o` pulses high for exactly one system clock after an edge with `host_rd_i`=1 during the opcode, the address or the write-data phase. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the management signals |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_i | input | 1 | Management clock from the host |
| mdo_i | input | 1 | Data bit driven by the host |
| host_rd_i | input | 1 | 1 when the host has released the data line and expects the PHY to drive it |
| mdi_o | output | 1 | Data bit returned to the host |
| dir_err_o | output | 1 | One-cycle pulse on a direction violation |

## Verification
Every result is due one system clock after the clock edge that first sees `mdc_i` high. The next state, `mdi_o` and `dir_err_o` are all registered on that edge. The bench changes its inputs on falling clock edges, raises `mdc_i` one cycle later, and samples on the falling edge after that, where it compares against a behavioural model of the frame. It then holds `mdc_i` high for one or more further cycles and checks that `mdi_o` holds and that `dir_err_o` has already dropped. A stored write is observed only through a later read frame, which covers the rule that storage happens on the last data edge.

// File: rtl/mdio_phy_pkg.sv
package mdio_phy_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_START,
        ST_OPCODE,
        ST_ADDR,
        ST_TURN,
        ST_DATA,
        ST_IDLE
    } mdio_state_e;

    localparam logic [1:0]  OP_READ    = 2'b10;
    localparam logic [1:0]  OP_WRITE   = 2'b01;

    // PHY 0 status word: 100TX FD, 10T FD, AN complete, AN able, link up
    localparam int          STATUS_IDX = 1;
    localparam logic [15:0] STATUS_RST = 16'h502C;

endpackage

// File: rtl/mdio_edge_det.sv
module mdio_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    output logic rise_o
);
    logic mdc_d, mdc_q;

    always_comb begin
        mdc_d  = mdc_i;
        rise_o = mdc_i & ~mdc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mdc_q <= 1'b0;
        else        mdc_q <= mdc_d;
    end
endmodule

// File: rtl/mdio_reg_array.sv
module mdio_reg_array
    import mdio_phy_pkg::*;
#(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [PHY_W+REG_W-1:0] idx_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [DATA_W-1:0]      rdata_o
);
    localparam int DEPTH = 1 << (PHY_W + REG_W);

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    function automatic logic [DATA_W-1:0] rst_word(input int idx);
        return (idx == STATUS_IDX) ? DATA_W'(STATUS_RST) : '0;
    endfunction

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[idx_i] = wdata_i;
        rdata_o = mem_q[idx_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= rst_word(i);
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_phy_pkg::*;
#(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rise_i,
    input  logic                   mdo_i,
    input  logic                   host_rd_i,
    input  logic [DATA_W-1:0]      rd_word_i,
    output logic [PHY_W+REG_W-1:0] idx_o,
    output logic                   we_o,
    output logic [DATA_W-1:0]      wdata_o,
    output logic                   mdi_o,
    output logic                   dir_err_o
);
    // Frame positions on the single bit counter
    localparam int PHY_END  = 2 + PHY_W;
    localparam int ADDR_END = PHY_END + REG_W;
    localparam int RD_END   = ADDR_END + DATA_W;
    localparam int WR_END   = ADDR_END + 1 + DATA_W;
    localparam int IDLE_END = WR_END + 2;
    localparam int CNT_W    = $clog2(IDLE_END + 1);
    localparam int DIDX_W   = $clog2(DATA_W);

    localparam logic [CNT_W-1:0] C_ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_PHY_END  = CNT_W'(PHY_END);
    localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(ADDR_END);
    localparam logic [CNT_W-1:0] C_RD_END   = CNT_W'(RD_END);
    localparam logic [CNT_W-1:0] C_WR_END   = CNT_W'(WR_END);
    localparam logic [CNT_W-1:0] C_IDLE_END = CNT_W'(IDLE_END);

    typedef struct packed {
        mdio_state_e        state;
        logic [CNT_W-1:0]   cnt;
        logic [1:0]         op;
        logic [PHY_W-1:0]   phy;
        logic [REG_W-1:0]   regad;
        logic [DATA_W-1:0]  wdata;
        logic               mdi;
        logic               err;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [CNT_W-1:0] rd_pos;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.err = 1'b0;
        we_o      = 1'b0;
        wdata_o   = {fsm_q.wdata[DATA_W-2:0], mdo_i};
        rd_pos    = C_RD_END - fsm_q.cnt;

        if (rise_i) begin
            fsm_d.mdi = 1'b0;
            case (fsm_q.state)
                ST_RESET: begin
                    if (!mdo_i && !host_rd_i) fsm_d.state = ST_START;
                end
                ST_START: begin
                    if (host_rd_i) begin
                        fsm_d.state = ST_RESET;
                    end else if (mdo_i) begin
                        fsm_d.state = ST_OPCODE;
                        fsm_d.cnt   = '0;
                        fsm_d.op    = '0;
                        fsm_d.phy   = '0;
                        fsm_d.regad = '0;
                        fsm_d.wdata = '0;
                    end
                end
                ST_OPCODE: begin
                    fsm_d.err = host_rd_i;
                    fsm_d.op  = {fsm_q.op[0], mdo_i};
                    fsm_d.cnt = fsm_q.cnt + C_ONE;
                    if (fsm_q.cnt == C_ONE) fsm_d.state = ST_ADDR;
                end
                ST_ADDR: begin
                    fsm_d.err = host_rd_i;
                    if (fsm_q.cnt < C_PHY_END)
                        fsm_d.phy = {fsm_q.phy[PHY_W-2:0], mdo_i};
                    else
                        fsm_d.regad = {fsm_q.regad[REG_W-2:0], mdo_i};
                    fsm_d.cnt = fsm_q.cnt + C_ONE;
                    if (fsm_d.cnt == C_ADDR_END) fsm_d.state = ST_TURN;
                end
                ST_TURN: begin
                    fsm_d.cnt = fsm_q.cnt + C_ONE;
                    if (fsm_q.op == OP_READ) begin
                        fsm_d.state = ST_DATA;
                    end else if (fsm_q.op == OP_WRITE) begin
                        if (fsm_q.cnt == C_ADDR_END + C_ONE) fsm_d.state = ST_DATA;
                    end else begin
                        fsm_d.state = ST_RESET;
                    end
                end
                ST_DATA: begin
                    fsm_d.cnt = fsm_q.cnt + C_ONE;
                    if (fsm_q.op == OP_READ) begin
                        if (host_rd_i) fsm_d.mdi = rd_word_i[rd_pos[DIDX_W-1:0]];
                        if (fsm_q.cnt == C_RD_END) fsm_d.state = ST_IDLE;
                    end else begin
                        fsm_d.err   = host_rd_i;
                        fsm_d.wdata = wdata_o;
                        if (fsm_q.cnt == C_WR_END) begin
                            we_o        = 1'b1;
                            fsm_d.state = ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    fsm_d.cnt = fsm_q.cnt + C_ONE;
                    if (fsm_d.cnt == C_IDLE_END) fsm_d.state = ST_RESET;
                end
                default: fsm_d.state = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= '0;
            fsm_q.state <= ST_RESET;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign idx_o     = {fsm_q.phy, fsm_q.regad};
    assign mdi_o     = fsm_q.mdi;
    assign dir_err_o = fsm_q.err;
endmodule

// File: rtl/mdio_phy_slave.sv
module mdio_phy_slave #(
    parameter int PHY_W  = 5,
    parameter int REG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdo_i,
    input  logic host_rd_i,
    output logic mdi_o,
    output logic dir_err_o
);
    localparam int IDX_W = PHY_W + REG_W;

    logic              mdc_rise;
    logic              wr_en;
    logic [IDX_W-1:0]  reg_idx;
    logic [DATA_W-1:0] wr_word;
    logic [DATA_W-1:0] rd_word;

    mdio_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_i  (mdc_i),
        .rise_o (mdc_rise)
    );

    mdio_frame_fsm #(
        .PHY_W  (PHY_W),
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (mdc_rise),
        .mdo_i     (mdo_i),
        .host_rd_i (host_rd_i),
        .rd_word_i (rd_word),
        .idx_o     (reg_idx),
        .we_o      (wr_en),
        .wdata_o   (wr_word),
        .mdi_o     (mdi_o),
        .dir_err_o (dir_err_o)
    );

    mdio_reg_array #(
        .PHY_W  (PHY_W),
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .idx_i   (reg_idx),
        .wdata_i (wr_word),
        .rdata_o (rd_word)
    );
endmodule

// File: rtl/mdio_phy_slave_chk.sv
module mdio_phy_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic host_rd_i,
    input logic mdc_rise,
    input logic wr_en,
    input logic mdi_o,
    input logic dir_err_o
);
    // R2: without a management edge the returned bit holds
    p_hold_without_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mdc_rise |=> $stable(mdi_o));

    // R10: the error pulse only follows an edge
    p_err_after_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mdc_rise |=> !dir_err_o);

    // R10: the error pulse needs the host claiming to read
    p_err_needs_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dir_err_o |-> $past(host_rd_i));

    // R6: a 1 on the data output appears only after an edge with the line released
    p_mdi_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdi_o) |-> ($past(host_rd_i) && $past(mdc_rise)));

    // R7: storage happens only on a management edge
    p_store_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> mdc_rise);
endmodule

bind mdio_phy_slave mdio_phy_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_rd_i (host_rd_i),
    .mdc_rise  (mdc_rise),
    .wr_en     (wr_en),
    .mdi_o     (mdi_o),
    .dir_err_o (dir_err_o)
);

// File: tb/mdio_phy_slave_tb.sv
`timescale 1ns/1ps
module mdio_phy_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic mdo = 1'b1;
    logic hrd = 1'b0;
    logic mdi_o, dir_err_o;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int exp_regs [1024];
    int m_ph, m_cnt, m_op, m_phy, m_reg, m_wd;
    bit m_mdi, m_err;
    bit last_mdi, last_err;

    always #5 clk = ~clk;

    mdio_phy_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc_i     (mdc),
        .mdo_i     (mdo),
        .host_rd_i (hrd),
        .mdi_o     (mdi_o),
        .dir_err_o (dir_err_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string phase_tag(input int ph, input int op);
        case (ph)
            0, 1:    return "R3";
            2:       return "R4";
            3:       return "R5";
            4:       return "R9";
            5:       return (op == 2) ? "R6" : "R7";
            default: return "R8";
        endcase
    endfunction

    // phases: 0 wait-0, 1 wait-1, 2 opcode, 3 address, 4 turnaround, 5 data, 6 idle
    task automatic model_edge(input bit o, input bit d);
        m_mdi = 1'b0;
        m_err = 1'b0;
        case (m_ph)
            0: if (!o && !d) m_ph = 1;
            1: begin
                if (d) m_ph = 0;
                else if (o) begin
                    m_ph = 2; m_cnt = 0; m_op = 0; m_phy = 0; m_reg = 0; m_wd = 0;
                end
            end
            2: begin
                m_err = d; m_op = (m_op * 2 + o) % 4; m_cnt++;
                if (m_cnt == 2) m_ph = 3;
            end
            3: begin
                m_err = d;
                if (m_cnt < 7) m_phy = m_phy * 2 + o;
                else           m_reg = m_reg * 2 + o;
                m_cnt++;
                if (m_cnt == 12) m_ph = 4;
            end
            4: begin
                if (m_op == 2) m_ph = 5;
                else if (m_op == 1) begin if (m_cnt == 13) m_ph = 5; end
                else m_ph = 0;
                m_cnt++;
            end
            5: begin
                if (m_op == 2) begin
                    if (d) m_mdi = bit'((exp_regs[m_phy * 32 + m_reg] >> (28 - m_cnt)) & 1);
                    if (m_cnt == 28) m_ph = 6;
                end else begin
                    m_err = d;
                    m_wd = (m_wd * 2 + o) & 16'hFFFF;
                    if (m_cnt == 29) begin
                        exp_regs[m_phy * 32 + m_reg] = m_wd;
                        m_ph = 6;
                    end
                end
                m_cnt++;
            end
            default: begin
                m_cnt++;
                if (m_cnt >= 31) m_ph = 0;
            end
        endcase
    endtask

    // one management clock; hold = extra cycles with MDC kept high
    task automatic send_bit(input bit o, input bit d, input int hold);
        string tag;
        @(negedge clk); mdo = o; hrd = d; mdc = 1'b0;
        @(negedge clk); mdc = 1'b1;
        tag = phase_tag(m_ph, m_op);
        model_edge(o, d);
        @(negedge clk);
        chk(tag, "mdi after edge", mdi_o, m_mdi);
        chk(tag, "dir_err after edge", dir_err_o, m_err);
        last_mdi = mdi_o;
        last_err = dir_err_o;
        for (int k = 0; k < 1 + hold; k++) begin
            @(negedge clk);
            if (hold > 0) mdo = ~mdo;
            chk("R2", "mdi held while mdc high", mdi_o, m_mdi);
            chk("R10", "dir_err single pulse", dir_err_o, 0);
        end
    endtask

    task automatic read_frame(input int op, input int phy, input int rg, input int pre,
                              input int idle, input bit drv, input int bad, input int hold,
                              output int word);
        repeat (pre) send_bit(1, 0, 0);
        send_bit(0, 0, 0);
        send_bit(1, 0, 0);
        send_bit(bit'(op >> 1), 0, 0);
        send_bit(bit'(op & 1), 0, 0);
        for (int i = 0; i < 10; i++) begin
            bit b = (i < 5) ? bit'((phy >> (4 - i)) & 1) : bit'((rg >> (9 - i)) & 1);
            send_bit(b, bit'(i == bad), 0);
            if (i == bad) chk("R10", "address-phase direction error", last_err, 1);
        end
        send_bit(1, 1, 0);
        word = 0;
        for (int i = 0; i < 16; i++) begin
            send_bit(1, drv, hold);
            word = (word << 1) | int'(last_mdi);
        end
        repeat (idle) send_bit(1, 0, 0);
    endtask

    task automatic write_frame(input int phy, input int rg, input int val, input int pre,
                               input int idle, input int bad);
        repeat (pre) send_bit(1, 0, 0);
        send_bit(0, 0, 0);
        send_bit(1, 0, 0);
        send_bit(0, 0, 0);
        send_bit(1, 0, 0);
        for (int i = 0; i < 10; i++) begin
            bit b = (i < 5) ? bit'((phy >> (4 - i)) & 1) : bit'((rg >> (9 - i)) & 1);
            send_bit(b, 0, 0);
        end
        send_bit(1, 0, 0);
        send_bit(0, 0, 0);
        for (int i = 0; i < 16; i++) begin
            send_bit(bit'((val >> (15 - i)) & 1), bit'(i == bad), 0);
            if (i == bad) chk("R10", "write-data direction error", last_err, 1);
        end
        repeat (idle) send_bit(1, 0, 0);
    endtask

    initial begin
        int w;
        for (int i = 0; i < 1024; i++) exp_regs[i] = 0;
        exp_regs[1] = 16'h502C;
        m_ph = 0; m_cnt = 0; m_op = 0; m_phy = 0; m_reg = 0; m_wd = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mdi at reset", mdi_o, 0);
        chk("R1", "dir_err at reset", dir_err_o, 0);

        // R1/R6: status word of PHY 0
        read_frame(2, 0, 1, 2, 2, 1, -1, 0, w);
        chk("R1", "PHY0 reg1 reset value", w, 16'h502C);
        read_frame(2, 3, 7, 2, 2, 1, -1, 0, w);
        chk("R1", "other register resets to 0", w, 0);

        // R7/R5: write and read back, address order checked by the swapped index
        write_frame(5, 18, 16'hA5C3, 2, 2, -1);
        read_frame(2, 5, 18, 2, 2, 1, -1, 0, w);
        chk("R7", "readback phy5 reg18", w, 16'hA5C3);
        read_frame(2, 18, 5, 2, 2, 1, -1, 0, w);
        chk("R5", "swapped address untouched", w, 0);
        write_frame(31, 31, 16'h8001, 2, 2, -1);
        read_frame(2, 31, 31, 2, 2, 1, -1, 0, w);
        chk("R7", "readback phy31 reg31", w, 16'h8001);

        // R6: host not released during read data -> zeros
        read_frame(2, 0, 1, 2, 2, 0, -1, 0, w);
        chk("R6", "no drive without direction", w, 0);

        // R2: MDC held high between data bits
        read_frame(2, 5, 18, 2, 2, 1, -1, 3, w);
        chk("R2", "read with long MDC high", w, 16'hA5C3);

        // R4/R9: invalid opcodes 11 and 00 drive nothing
        read_frame(3, 0, 1, 2, 2, 1, -1, 0, w);
        chk("R4", "opcode 11 returns no data", w, 0);
        read_frame(0, 0, 1, 2, 2, 1, -1, 0, w);
        chk("R4", "opcode 00 returns no data", w, 0);

        // R3: direction set while waiting for the 1 aborts the start
        send_bit(1, 0, 0); send_bit(0, 0, 0); send_bit(1, 1, 0);
        w = 0;
        for (int i = 0; i < 16; i++) begin
            send_bit(1, 1, 0);
            w = (w << 1) | int'(last_mdi);
        end
        chk("R3", "aborted start stays quiet", w, 0);
        read_frame(2, 0, 1, 2, 2, 1, -1, 0, w);
        chk("R3", "clean start after abort", w, 16'h502C);

        // R10: direction errors in address and write data; write still lands
        read_frame(2, 0, 1, 2, 2, 1, 3, 0, w);
        chk("R10", "read after address error", w, 16'h502C);
        write_frame(7, 2, 16'h1234, 2, 2, 9);
        read_frame(2, 7, 2, 2, 2, 1, -1, 0, w);
        chk("R10", "write with data-phase error", w, 16'h1234);

        // R8: after a read, two idle edges swallow an immediate start
        read_frame(2, 0, 1, 2, 0, 1, -1, 0, w);
        read_frame(2, 0, 1, 0, 2, 1, -1, 0, w);
        chk("R8", "start during read idle ignored", w, 0);
        repeat (40) send_bit(1, 0, 0);
        // R8: after a write, one idle edge is enough
        write_frame(9, 4, 16'h0F0F, 2, 1, -1);
        read_frame(2, 9, 4, 0, 2, 1, -1, 0, w);
        chk("R8", "re-armed after write idle", w, 16'h0F0F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule